// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces the control-memory address for the next microinstruction, one new address per clock. It keeps a 7-bit control address register, driven out as the address into control memory, and a single subroutine return register. Each cycle the branch-type, condition-select and branch-address fields of the microinstruction being executed arrive on input ports. The sequencer combines them with three status bits from the datapath and the opcode bits of the instruction register to pick the next address.

Four address sources exist: the current address plus one, the branch address from the microinstruction, the saved return address, and an address derived from the opcode. A four-way condition multiplexer picks the status bit that qualifies jumps and calls. The control memory, its contents and the datapath are outside the block and are reached only through ports.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_ni` is low the address register reads 0 and the return register is 0. A return issued as the first operation after reset therefore goes to address 0.
- R2: `cond_sel_i` selects the branch condition as follows: 2'b00 is always true, 2'b01 is `dr_sign_i`, 2'b10 is `ac_sign_i`, and 2'b11 is `ac_zero_i`.
- R3: With `br_op_i` = 2'b00 (jump), the next address is `br_addr_i` when the condition is true. Otherwise it is the current address plus 1.
- R4: With `br_op_i` = 2'b01 (call) and a true condition, the next address is `br_addr_i` and the return register takes the current address plus 1. With a false condition the address increments and the return register is unchanged.
- R5: With `br_op_i` = 2'b10 (return), the next address is the return register, whatever the condition.
- R6: With `br_op_i` = 2'b11 (map), the next address has bits 5..2 equal to `opcode_i` and bits 6, 1 and 0 equal to zero, whatever the condition.
- R7: The return register holds one level only. A second taken call before a return overwrites it, and only a taken call writes it.
- R8: Increment and return-address arithmetic wrap modulo 128: address 127 plus 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_sel_i | input | 2 | Condition select field of the current microinstruction |
| br_op_i | input | 2 | Branch-type field of the current microinstruction |
| br_addr_i | input | 7 | Branch address field of the current microinstruction |
| dr_sign_i | input | 1 | Data register bit 15 |
| ac_sign_i | input | 1 | Accumulator bit 15 (sign) |
| ac_zero_i | input | 1 | Accumulator equals zero |
| opcode_i | input | 4 | Opcode bits of the instruction register (bits 14..11) |
| car_o | output | 7 | Control address register, the address into control memory |

## Verification
On every cycle the assertions check the per-operation address update against the previous cycle's fields and register values. This covers taken and not-taken jumps and calls, the return-register write or hold, unconditional returns, the map layout and the fixed always-true condition. The return register is internal. Whether it holds the right level after several calls, and whether reset clears it, only shows up when the bench's scenarios issue a return and compare the address. Those scenarios sweep every opcode, condition select, status combination and branch type. Wrap-around at the top address and reset in the middle of a run are covered by dedicated sequences.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_op_e;

  typedef enum logic [1:0] {
    CD_ALWAYS  = 2'b00,
    CD_DR_SIGN = 2'b01,
    CD_AC_SIGN = 2'b10,
    CD_AC_ZERO = 2'b11
  } cond_sel_e;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  cond_sel_e sel_i,
  input  logic      dr_sign_i,
  input  logic      ac_sign_i,
  input  logic      ac_zero_i,
  output logic      cond_o
);
  always_comb begin
    unique case (sel_i)
      CD_ALWAYS:  cond_o = 1'b1;
      CD_DR_SIGN: cond_o = dr_sign_i;
      CD_AC_SIGN: cond_o = ac_sign_i;
      default:    cond_o = ac_zero_i;
    endcase
  end
endmodule

// File: rtl/useq_addr_map.sv
module useq_addr_map #(
  parameter int unsigned AW    = 7,
  parameter int unsigned OPW   = 4,
  parameter int unsigned SHIFT = 2
) (
  input  logic [OPW-1:0] opcode_i,
  output logic [AW-1:0]  map_addr_o
);
  localparam int unsigned HI = SHIFT + OPW;

  // opcode placed at [HI-1:SHIFT]; all other bits zero
  for (genvar b = 0; b < AW; b++) begin : g_bit
    if (b >= SHIFT && b < HI) begin : g_op
      assign map_addr_o[b] = opcode_i[b-SHIFT];
    end else begin : g_zero
      assign map_addr_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/useq_next_mux.sv
module useq_next_mux
  import useq_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  br_op_e        op_i,
  input  logic          cond_i,
  input  logic [AW-1:0] car_i,
  input  logic [AW-1:0] sbr_i,
  input  logic [AW-1:0] br_addr_i,
  input  logic [AW-1:0] map_addr_i,
  output logic [AW-1:0] next_car_o,
  output logic [AW-1:0] incr_o,
  output logic          sbr_we_o
);
  assign incr_o = car_i + AW'(1);

  always_comb begin
    sbr_we_o = 1'b0;
    unique case (op_i)
      BR_JMP:  next_car_o = cond_i ? br_addr_i : incr_o;
      BR_CALL: begin
        next_car_o = cond_i ? br_addr_i : incr_o;
        sbr_we_o   = cond_i;
      end
      BR_RET:  next_car_o = sbr_i;
      default: next_car_o = map_addr_i;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned AW        = 7,
  parameter int unsigned OPW       = 4,
  parameter int unsigned MAP_SHIFT = 2,
  parameter logic [AW-1:0] START   = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cond_sel_i,
  input  logic [1:0]    br_op_i,
  input  logic [AW-1:0] br_addr_i,
  input  logic          dr_sign_i,
  input  logic          ac_sign_i,
  input  logic          ac_zero_i,
  input  logic [OPW-1:0] opcode_i,
  output logic [AW-1:0] car_o
);
  logic [AW-1:0] car_q, sbr_q, next_car, incr, map_addr;
  logic          cond, sbr_we;
  br_op_e        op;
  cond_sel_e     csel;

  assign op   = br_op_e'(br_op_i);
  assign csel = cond_sel_e'(cond_sel_i);

  useq_cond_mux u_cond (
    .sel_i(csel), .dr_sign_i(dr_sign_i), .ac_sign_i(ac_sign_i),
    .ac_zero_i(ac_zero_i), .cond_o(cond)
  );

  useq_addr_map #(.AW(AW), .OPW(OPW), .SHIFT(MAP_SHIFT)) u_map (
    .opcode_i(opcode_i), .map_addr_o(map_addr)
  );

  useq_next_mux #(.AW(AW)) u_next (
    .op_i(op), .cond_i(cond), .car_i(car_q), .sbr_i(sbr_q),
    .br_addr_i(br_addr_i), .map_addr_i(map_addr),
    .next_car_o(next_car), .incr_o(incr), .sbr_we_o(sbr_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= START;
      sbr_q <= '0;
    end else begin
      car_q <= next_car;
      if (sbr_we) sbr_q <= incr;
    end
  end

  assign car_o = car_q;

  // R2
  p_cond_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 2'b00) |-> cond);

  p_jmp_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b00 && cond) |=> car_q == $past(br_addr_i));

  p_jmp_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b00 && !cond) |=> car_q == AW'($past(car_q) + AW'(1)));

  p_call_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b01 && cond) |=>
      (car_q == $past(br_addr_i) && sbr_q == AW'($past(car_q) + AW'(1))));

  p_call_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b01 && !cond) |=>
      (car_q == AW'($past(car_q) + AW'(1)) && $stable(sbr_q)));

  p_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b10) |=> (car_q == $past(sbr_q) && $stable(sbr_q)));

  p_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == 2'b11) |=>
      (car_q[MAP_SHIFT+OPW-1:MAP_SHIFT] == $past(opcode_i) &&
       car_q[MAP_SHIFT-1:0] == '0 && car_q[AW-1] == 1'b0));

  // R7: only a taken call changes the return register
  p_sbr_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_op_i == 2'b01 && cond) |=> $stable(sbr_q));
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cond_sel, br_op;
  logic [6:0] br_addr;
  logic       dr_sign, ac_sign, ac_zero;
  logic [3:0] opcode;
  logic [6:0] car;

  logic [6:0] m_car, m_sbr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cond_sel_i(cond_sel), .br_op_i(br_op),
    .br_addr_i(br_addr), .dr_sign_i(dr_sign), .ac_sign_i(ac_sign),
    .ac_zero_i(ac_zero), .opcode_i(opcode), .car_o(car)
  );

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: car_o=%0d expected %0d", req, act, exp);
    end
  endtask

  // st = {ac_zero, ac_sign, dr_sign}
  task automatic apply(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad,
                       input logic [2:0] st, input logic [3:0] op, input string req);
    logic c;
    cond_sel = cd; br_op = br; br_addr = ad; opcode = op;
    {ac_zero, ac_sign, dr_sign} = st;
    @(posedge clk);
    case (cd)
      2'd0: c = 1'b1;
      2'd1: c = st[0];
      2'd2: c = st[1];
      default: c = st[2];
    endcase
    case (br)
      2'd0: m_car = c ? ad : 7'((m_car + 1) % 128);
      2'd1: begin
        if (c) begin m_sbr = 7'((m_car + 1) % 128); m_car = ad; end
        else m_car = 7'((m_car + 1) % 128);
      end
      2'd2: m_car = m_sbr;
      default: m_car = 7'(op * 4);
    endcase
    @(negedge clk);
    check(car, m_car, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: car_o=%0d expected completion", car);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cond_sel = 0; br_op = 0; br_addr = 0; dr_sign = 0; ac_sign = 0; ac_zero = 0; opcode = 0;
    m_car = 0; m_sbr = 0;
    repeat (3) @(negedge clk);
    check(car, 7'd0, "R1 reset address");
    rst_ni = 1'b1;
    apply(2'd0, 2'd2, 7'd55, 3'b000, 4'd0, "R1 return after reset");

    // R8 wrap
    apply(2'd0, 2'd0, 7'd127, 3'b000, 4'd0, "R3 jump to 127");
    apply(2'd1, 2'd0, 7'd9, 3'b000, 4'd0, "R8 increment wraps");
    apply(2'd0, 2'd0, 7'd127, 3'b000, 4'd0, "R3 jump to 127");
    apply(2'd0, 2'd1, 7'd40, 3'b000, 4'd0, "R8 call from 127");
    apply(2'd0, 2'd2, 7'd3, 3'b000, 4'd0, "R8 return wraps to 0");

    // R7 overwrite and not-taken call
    apply(2'd0, 2'd1, 7'd20, 3'b000, 4'd0, "R4 first call");
    apply(2'd0, 2'd1, 7'd70, 3'b000, 4'd0, "R7 second call");
    apply(2'd3, 2'd1, 7'd99, 3'b000, 4'd0, "R7 untaken call");
    apply(2'd0, 2'd2, 7'd0, 3'b000, 4'd0, "R7 return to second level");

    // exhaustive sweep
    for (int op = 0; op < 16; op++)
      for (int st = 0; st < 8; st++)
        for (int cd = 0; cd < 4; cd++)
          for (int br = 0; br < 4; br++)
            apply(2'(cd), 2'(br), 7'((op * 37 + st * 11 + cd * 5 + br * 3) % 128),
                  3'(st), 4'(op),
                  br == 0 ? "R3/R2 jump" : br == 1 ? "R4/R7 call" :
                  br == 2 ? "R5 return" : "R6 map");

    // mid-run reset
    apply(2'd0, 2'd1, 7'd33, 3'b000, 4'd0, "R4 call before reset");
    rst_ni = 1'b0;
    m_car = 0; m_sbr = 0;
    @(posedge clk); @(negedge clk);
    check(car, 7'd0, "R1 mid-run reset");
    rst_ni = 1'b1;
    apply(2'd0, 2'd2, 7'd12, 3'b111, 4'd5, "R1 return register cleared");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule